// File: doc/BRIEF.md
# Four-Stage Pipeline with Scoped Stall Control

The block is a four-stage register pipeline, stages numbered 0 (input end) to 3 (output end). Any stage may raise a stall request. A two-bit scope input chooses what that request holds: the requesting stage together with every stage before it, the entire pipeline, or only the stages before the requester while the requester itself keeps moving. Stages that are not held advance every cycle.

Each stage owns an 8-bit activity counter. The counter increments in every cycle in which the stage is not held. A record travels down the pipe with one 8-bit snapshot field per stage. When a stage advances, it writes its newly incremented counter value into its own field of the record it loads. When a stage advances while the stage before it is held, it takes in an invalid bubble. The bubble keeps the upstream snapshot fields that the stage already held. The record in stage 3 appears at the output together with its valid bit. Registered per-stage stalled flags and a whole-pipeline stalled flag report the decision taken for the cycle that has just ended.

The block serves as a reference structure for stall resolution. It has no datapath arithmetic and no handshake at its edges.

Top module: `stall_pipe`

## Requirements
- R1: While rst_ni is low, every counter, valid bit, snapshot field and flag is zero. All outputs read zero.
- R2: Starting from reset with no requests, after k idle cycles (k ≤ 4) field 3 of out_snap_o (bits 31:24) reads k. After four idle cycles out_snap_o reads fields 4,3,2,1 for stages 3,2,1,0 (stage s in bits s*8+7:s*8), and out_valid_o is 1.
- R3: Scope code 0 with requester n holds stages 0..n. Stages above n advance. A request from stage 3 under code 0 therefore sets pipe_stalled_o.
- R4: Scope code 1 holds all four stages and sets pipe_stalled_o, whichever stage raised the request.
- R5: Scope code 2 with requester n holds only stages 0..n-1, and pipe_stalled_o stays low. With n = 0 no stage is held.
- R6: Scope code 3 behaves exactly like scope code 0.
- R7: When several request bits are set in one cycle, the highest-numbered requester alone sets the scope.
- R8: A stage counter increments by one, wrapping modulo 256, in every cycle in which the stage is not held. A held stage keeps its counter and its record unchanged.
- R9: A stage that advances while its predecessor is held loads a record with the valid bit cleared. That record keeps the stage's previous upstream fields and writes its own field with its new counter value. A valid record moves on only when both neighbours advance.
- R10: stage_stalled_o[s] (bit s for stage s) and pipe_stalled_o are registered, one cycle after the request. pipe_stalled_o is 1 exactly when all four stages were held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_req_i | input | 4 | Stall request, bit s from stage s |
| stall_scope_i | input | 2 | 0: requester and upstream, 1: whole pipe, 2: upstream only, 3: as 0 |
| out_valid_o | output | 1 | Valid bit of the record in stage 3 |
| out_snap_o | output | 32 | Snapshot fields of the record in stage 3, stage s in bits s*8+7:s*8 |
| stage_stalled_o | output | 4 | Registered hold flags, bit s for stage s |
| pipe_stalled_o | output | 1 | Registered flag: all stages were held |

## Verification
Directed patterns run first. An idle start-up shows the record filling in from the output field backwards. A stage-3 request under each scope code shows the difference between a full freeze and the prefix and upstream-only holds. A stage-0 upstream-only request must hold nothing. A two-bit request shows whether the highest requester decides the scope. Repeated mid-pipe holds drain bubbles to the output, which separates valid records from bubbles. A long seeded random run then mixes single, multiple and absent requests across all four codes. It compares every output each cycle against a bench model, which also covers counter wrap after 256 advances.

// File: rtl/pstall_pkg.sv
package pstall_pkg;
  typedef enum logic [1:0] {
    SCOPE_SELF_UP = 2'd0,
    SCOPE_WHOLE   = 2'd1,
    SCOPE_UP_ONLY = 2'd2,
    SCOPE_ALT     = 2'd3
  } scope_e;
endpackage

// File: rtl/stall_resolver.sv
module stall_resolver
  import pstall_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4
) (
  input  logic [NUM_STAGES-1:0] req_i,
  input  logic [1:0]            scope_i,
  output logic [NUM_STAGES-1:0] hold_o
);
  localparam int unsigned IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;

  logic             any_req;
  logic [IDX_W-1:0] top_idx;
  scope_e           scope;

  assign scope   = scope_e'(scope_i);
  assign any_req = |req_i;

  // highest requester wins
  always_comb begin
    top_idx = '0;
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (req_i[s]) top_idx = IDX_W'(s);
    end
  end

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_mask
    always_comb begin
      unique case (scope)
        SCOPE_WHOLE:   hold_o[g] = any_req;
        SCOPE_UP_ONLY: hold_o[g] = any_req && (IDX_W'(g) < top_idx);
        default:       hold_o[g] = any_req && (IDX_W'(g) <= top_idx);
      endcase
    end
  end
endmodule

// File: rtl/pipe_stage.sv
module pipe_stage #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned STAGE_IDX  = 0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        adv_i,
  input  logic                        feed_i,
  input  logic                        up_valid_i,
  input  logic [NUM_STAGES*CNT_W-1:0] up_snap_i,
  output logic                        valid_o,
  output logic [NUM_STAGES*CNT_W-1:0] snap_o
);
  localparam int unsigned SNAP_W = NUM_STAGES * CNT_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              valid_q;
  logic [SNAP_W-1:0] snap_q;
  logic [SNAP_W-1:0] snap_nxt;

  assign cnt_nxt = cnt_q + CNT_W'(1);

  // bubble keeps own upstream fields; own field always refreshed
  always_comb begin
    snap_nxt = feed_i ? up_snap_i : snap_q;
    snap_nxt[STAGE_IDX*CNT_W +: CNT_W] = cnt_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
      snap_q  <= '0;
    end else if (adv_i) begin
      cnt_q   <= cnt_nxt;
      valid_q <= feed_i & up_valid_i;
      snap_q  <= snap_nxt;
    end
  end

  assign valid_o = valid_q;
  assign snap_o  = snap_q;
endmodule

// File: rtl/stall_pipe.sv
module stall_pipe #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned CNT_W      = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_STAGES-1:0]       stall_req_i,
  input  logic [1:0]                  stall_scope_i,
  output logic                        out_valid_o,
  output logic [NUM_STAGES*CNT_W-1:0] out_snap_o,
  output logic [NUM_STAGES-1:0]       stage_stalled_o,
  output logic                        pipe_stalled_o
);
  localparam int unsigned SNAP_W = NUM_STAGES * CNT_W;

  logic [NUM_STAGES-1:0]             hold;
  logic [NUM_STAGES-1:0]             adv;
  logic [NUM_STAGES-1:0]             feed;
  logic [NUM_STAGES-1:0]             valid_w;
  logic [NUM_STAGES-1:0][SNAP_W-1:0] snap_w;
  logic [NUM_STAGES-1:0]             stalled_q;
  logic                              pipe_q;

  stall_resolver #(.NUM_STAGES(NUM_STAGES)) resolver_i (
    .req_i   (stall_req_i),
    .scope_i (stall_scope_i),
    .hold_o  (hold)
  );

  assign adv = ~hold;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic              up_valid;
    logic [SNAP_W-1:0] up_snap;
    if (g == 0) begin : g_src
      assign feed[g]  = 1'b1;
      assign up_valid = 1'b1;
      assign up_snap  = '0;
    end else begin : g_link
      assign feed[g]  = adv[g-1];
      assign up_valid = valid_w[g-1];
      assign up_snap  = snap_w[g-1];
    end

    pipe_stage #(
      .NUM_STAGES (NUM_STAGES),
      .CNT_W      (CNT_W),
      .STAGE_IDX  (g)
    ) stage_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .adv_i      (adv[g]),
      .feed_i     (feed[g]),
      .up_valid_i (up_valid),
      .up_snap_i  (up_snap),
      .valid_o    (valid_w[g]),
      .snap_o     (snap_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stalled_q <= '0;
      pipe_q    <= 1'b0;
    end else begin
      stalled_q <= hold;
      pipe_q    <= &hold;
    end
  end

  assign out_valid_o     = valid_w[NUM_STAGES-1];
  assign out_snap_o      = snap_w[NUM_STAGES-1];
  assign stage_stalled_o = stalled_q;
  assign pipe_stalled_o  = pipe_q;
endmodule

// File: rtl/stall_pipe_chk.sv
module stall_pipe_chk #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned CNT_W      = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_STAGES-1:0]       stall_req_i,
  input logic [1:0]                  stall_scope_i,
  input logic                        out_valid_o,
  input logic [NUM_STAGES*CNT_W-1:0] out_snap_o,
  input logic [NUM_STAGES-1:0]       stage_stalled_o,
  input logic                        pipe_stalled_o
);
  localparam int unsigned LAST = NUM_STAGES - 1;

  logic             armed_q;
  logic [CNT_W-1:0] last_field;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign last_field = out_snap_o[LAST*CNT_W +: CNT_W];

  // R3: held stages always form a prefix from stage 0
  assert_hold_prefix_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({1'b0, stage_stalled_o} + (NUM_STAGES+1)'(1)));

  // R4
  assert_whole_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|stall_req_i) && stall_scope_i == 2'd1) |=> pipe_stalled_o);

  // R5
  assert_up_only_runs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|stall_req_i) && stall_scope_i == 2'd2) |=> !pipe_stalled_o);

  // R10
  assert_no_req_no_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_req_i == '0) |=> (stage_stalled_o == '0 && !pipe_stalled_o));

  assert_pipe_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_stalled_o == (&stage_stalled_o));

  // R8: held last stage keeps its record
  assert_held_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_stalled_o[LAST] |-> ($stable(out_snap_o) && $stable(out_valid_o)));

  // R8: advancing last stage bumps its own field
  assert_field_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !stage_stalled_o[LAST]) |-> last_field == $past(last_field) + CNT_W'(1));
endmodule

bind stall_pipe stall_pipe_chk #(.NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .stall_req_i     (stall_req_i),
  .stall_scope_i   (stall_scope_i),
  .out_valid_o     (out_valid_o),
  .out_snap_o      (out_snap_o),
  .stage_stalled_o (stage_stalled_o),
  .pipe_stalled_o  (pipe_stalled_o)
);

// File: tb/stall_pipe_tb_top.sv
module stall_pipe_tb_top;
  localparam int N = 4;
  localparam int W = 8;
  localparam int WATCHDOG = 20000;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic [N-1:0]    stall_req_i;
  logic [1:0]      stall_scope_i;
  logic            out_valid_o;
  logic [N*W-1:0]  out_snap_o;
  logic [N-1:0]    stage_stalled_o;
  logic            pipe_stalled_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  logic [W-1:0]         m_cnt   [N];
  logic                 m_valid [N];
  logic [N-1:0][W-1:0]  m_snap  [N];
  logic [N-1:0]         m_flags;
  logic                 m_pipe;

  always #2 clk = ~clk;

  stall_pipe #(.NUM_STAGES(N), .CNT_W(W)) dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .stall_req_i     (stall_req_i),
    .stall_scope_i   (stall_scope_i),
    .out_valid_o     (out_valid_o),
    .out_snap_o      (out_snap_o),
    .stage_stalled_o (stage_stalled_o),
    .pipe_stalled_o  (pipe_stalled_o)
  );

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected <= %0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_hold(input logic [N-1:0] req, input logic [1:0] scope);
    int top = -1;
    logic [N-1:0] m = '0;
    for (int s = 0; s < N; s++) if (req[s]) top = s;
    if (top < 0) return '0;
    for (int s = 0; s < N; s++) begin
      case (scope)
        2'd1:    m[s] = 1'b1;
        2'd2:    m[s] = (s < top);
        default: m[s] = (s <= top);
      endcase
    end
    return m;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < N; s++) begin
      m_cnt[s] = '0; m_valid[s] = 1'b0; m_snap[s] = '0;
    end
    m_flags = '0; m_pipe = 1'b0;
  endtask

  task automatic model_step(input logic [N-1:0] req, input logic [1:0] scope);
    logic [N-1:0] h = exp_hold(req, scope);
    for (int s = N-1; s >= 0; s--) begin
      if (!h[s]) begin
        logic [W-1:0] nc = m_cnt[s] + 8'd1;
        if (s == 0) begin
          m_valid[0] = 1'b1;
          m_snap[0]  = '0;
        end else if (!h[s-1]) begin
          m_valid[s] = m_valid[s-1];
          m_snap[s]  = m_snap[s-1];
        end else begin
          m_valid[s] = 1'b0;
        end
        m_snap[s][s] = nc;
        m_cnt[s]     = nc;
      end
    end
    m_flags = h;
    m_pipe  = &h;
  endtask

  function automatic string scope_tag(input logic [N-1:0] req, input logic [1:0] scope);
    if ($countones(req) > 1) return "R7";
    case (scope)
      2'd1: return "R4";
      2'd2: return "R5";
      2'd3: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic compare_all(input logic [N-1:0] req, input logic [1:0] scope);
    string t = scope_tag(req, scope);
    check("R8", "out_snap", 64'(out_snap_o), 64'(m_snap[N-1]));
    check("R9", "out_valid", 64'(out_valid_o), 64'(m_valid[N-1]));
    check(t, "stage_stalled", 64'(stage_stalled_o), 64'(m_flags));
    check("R10", "pipe_stalled", 64'(pipe_stalled_o), 64'(m_pipe));
  endtask

  task automatic step(input logic [N-1:0] req, input logic [1:0] scope);
    stall_req_i   = req;
    stall_scope_i = scope;
    model_step(req, scope);
    @(posedge clk);
    @(negedge clk);
    compare_all(req, scope);
  endtask

  initial begin
    logic [N-1:0] r;
    logic [1:0]   sc;
    void'($urandom(32'h5eed_1234));
    rst_ni = 1'b0; stall_req_i = '0; stall_scope_i = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1", "reset out_valid", 64'(out_valid_o), 64'd0);
    check("R1", "reset out_snap", 64'(out_snap_o), 64'd0);
    check("R1", "reset flags", 64'({pipe_stalled_o, stage_stalled_o}), 64'd0);
    rst_ni = 1'b1;

    // R2: idle start-up
    for (int k = 1; k <= 4; k++) begin
      step('0, 2'd0);
      check("R2", "idle field3", 64'(out_snap_o[31:24]), 64'(k));
    end
    check("R2", "idle record", 64'(out_snap_o), 64'h04030201);
    check("R2", "idle valid", 64'(out_valid_o), 64'd1);

    step(4'b1000, 2'd0);
    check("R3", "stage3 plain pipe", 64'(pipe_stalled_o), 64'd1);
    step(4'b0100, 2'd1);
    check("R4", "whole pipe", 64'(pipe_stalled_o), 64'd1);
    step(4'b0100, 2'd2);
    check("R5", "upstream only flags", 64'(stage_stalled_o), 64'h3);
    check("R5", "upstream only pipe", 64'(pipe_stalled_o), 64'd0);
    step(4'b0001, 2'd2);
    check("R5", "stage0 upstream only", 64'(stage_stalled_o), 64'h0);
    step(4'b0010, 2'd3);
    check("R6", "alt code flags", 64'(stage_stalled_o), 64'h3);
    step(4'b1010, 2'd2);
    check("R7", "highest requester", 64'(stage_stalled_o), 64'h7);

    // R9: bubbles drain to output
    step(4'b0010, 2'd0);
    step(4'b0010, 2'd0);
    check("R9", "bubble at output", 64'(out_valid_o), 64'd0);
    step('0, 2'd0);
    step('0, 2'd0);
    step('0, 2'd0);
    check("R9", "valid after drain", 64'(out_valid_o), 64'd1);

    // random run (covers R8 wrap)
    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(0, 3))
        0:       r = '0;
        1:       r = N'($urandom_range(0, 15));
        default: r = N'(1) << $urandom_range(0, N-1);
      endcase
      sc = 2'($urandom_range(0, 3));
      step(r, sc);
    end

    // R1: asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1;
    check("R1", "async reset snap", 64'(out_snap_o), 64'd0);
    check("R1", "async reset flags", 64'({pipe_stalled_o, stage_stalled_o, out_valid_o}), 64'd0);

    done = 1;
    summary();
  end
endmodule